// File: doc/BRIEF.md
# Memory Error Status and Capture Registers

This block gathers error events from a memory controller's ECC decoder and from its address-range checker. It turns them into sticky status flags. Each error class has two flags. The first flag records that one event has happened. The second flag records that another event of the same class arrived while the first flag was still set. Two more flags report that memory initialization has finished and that some ECC event (correctable or uncorrectable) has occurred.

For each class, the block records the details of the first event: the address, the data word and the check syndrome. Those details stay fixed until software acknowledges that class. Software reaches the block through a simple word-wide register port: a write strobe, a register index and write data, with read data returned combinationally. Writing ones to the status register clears the matching flags. A mask register keeps flags from raising the single interrupt line.

The ECC arithmetic, the range decoding and the bus protocol belong to neighbouring logic.

Top module: `memerr_status_regs`

## Requirements
- R1: After reset, the status word is 0, the mask register (index 1) reads 8'hFF, the interrupt is low, and every capture register reads 0.
- R2: A single correctable event leaves the status word at exactly 8'h84 (bit 2 single-correctable, bit 7 any-ECC). Its address, data and syndrome are captured. The syndrome reads in bits 23:16 of register index 12.
- R3: A single uncorrectable event leaves the status word at exactly 8'h90 (bit 4 single-uncorrectable, bit 7 any-ECC). Its syndrome reads in bits 15:8 of register index 12.
- R4: An out-of-range access event sets status bit 0 only. It does not set bit 7. Its 33-bit address is captured.
- R5: An event of a class whose single flag is already set sets that class's repeat flag (bit 1 out-of-range, bit 3 correctable, bit 5 uncorrectable) and leaves the captured values of that class unchanged.
- R6: An initialization-complete pulse sets status bit 6.
- R7: A write to register index 0 clears each status bit whose write-data bit is 1 and leaves every other status bit unchanged.
- R8: When an event and an acknowledge of its class's flags happen in the same cycle, the event wins. The single flag (and bit 7 for an ECC event) stays set, the repeat flag is cleared, and the capture registers take the new event's values.
- R9: The interrupt output is high exactly when some status bit is set whose mask bit (register index 1, bits 7:0, 1 = masked) is 0.
- R10: Captured addresses read as a low word (bits 31:0) and a high register holding address bit 32 in bit 0. The register indices are: out-of-range 2/3, correctable 4/5, uncorrectable 8/9. Captured data reads as low and high words: correctable 6/7, uncorrectable 10/11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oor_evt_i | input | 1 | Out-of-range access event pulse |
| oor_addr_i | input | 33 | Address of the out-of-range access |
| ce_evt_i | input | 1 | Correctable ECC event pulse |
| ce_addr_i | input | 33 | Address of the correctable event |
| ce_data_i | input | 64 | Data word of the correctable event |
| ce_syn_i | input | 8 | Syndrome of the correctable event |
| ue_evt_i | input | 1 | Uncorrectable ECC event pulse |
| ue_addr_i | input | 33 | Address of the uncorrectable event |
| ue_data_i | input | 64 | Data word of the uncorrectable event |
| ue_syn_i | input | 8 | Syndrome of the uncorrectable event |
| init_evt_i | input | 1 | Memory initialization complete pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i (combinational) |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt, status gated by mask |

## Verification
An event pulse or register write sampled at a clock edge is visible at `status_o`, `irq_o` and through `reg_rdata_o` directly after that edge, since exactly one register stage lies in between. The read path adds no cycle. The bench drives every stimulus on a falling edge for one full cycle. It queues each expected value when it sets the read index on a later falling edge, and the monitor compares a quarter period after that falling edge. This places every comparison after the one register update it depends on and clear of the next rising edge.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
    localparam int WORD_W  = 32;
    localparam int STAT_W  = 8;
    localparam int RIDX_W  = 4;
    localparam int NCLS    = 3;

    // class numbering; class c owns status bits 2c (single) and 2c+1 (repeat)
    localparam int CLS_OOR = 0;
    localparam int CLS_CE  = 1;
    localparam int CLS_UE  = 2;

    localparam int ST_INIT = 6;
    localparam int ST_ECC  = 7;

    localparam logic [RIDX_W-1:0] RI_STATUS = 4'd0;
    localparam logic [RIDX_W-1:0] RI_MASK   = 4'd1;
    localparam logic [RIDX_W-1:0] RI_OOR_AL = 4'd2;
    localparam logic [RIDX_W-1:0] RI_OOR_AH = 4'd3;
    localparam logic [RIDX_W-1:0] RI_CE_AL  = 4'd4;
    localparam logic [RIDX_W-1:0] RI_CE_AH  = 4'd5;
    localparam logic [RIDX_W-1:0] RI_CE_DL  = 4'd6;
    localparam logic [RIDX_W-1:0] RI_CE_DH  = 4'd7;
    localparam logic [RIDX_W-1:0] RI_UE_AL  = 4'd8;
    localparam logic [RIDX_W-1:0] RI_UE_AH  = 4'd9;
    localparam logic [RIDX_W-1:0] RI_UE_DL  = 4'd10;
    localparam logic [RIDX_W-1:0] RI_UE_DH  = 4'd11;
    localparam logic [RIDX_W-1:0] RI_SYN    = 4'd12;

    typedef struct packed {
        logic single;
        logic multi;
    } cls_flags_t;
endpackage

// File: rtl/memerr_cls_trk.sv
module memerr_cls_trk
    import memerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic ack_single_i,
    input  logic ack_multi_i,
    output logic single_o,
    output logic multi_o,
    output logic capture_o
);
    cls_flags_t st_d, st_q;
    logic       free;

    always_comb begin
        // the slot is free if empty or being acknowledged this cycle
        free         = !st_q.single || ack_single_i;
        st_d.single  = (st_q.single & ~ack_single_i) | evt_i;
        st_d.multi   = (st_q.multi & ~ack_multi_i) | (evt_i & ~free);
        capture_o    = evt_i & free;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign single_o = st_q.single;
    assign multi_o  = st_q.multi;
endmodule

// File: rtl/memerr_capture.sv
module memerr_capture #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = en_i ? d_i : cap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign q_o = cap_q;
endmodule

// File: rtl/memerr_status_regs.sv
module memerr_status_regs
    import memerr_pkg::*;
#(
    parameter int              ADDR_W   = 33,
    parameter int              DATA_W   = 64,
    parameter int              SYN_W    = 8,
    parameter logic [STAT_W-1:0] MASK_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oor_evt_i,
    input  logic [ADDR_W-1:0] oor_addr_i,
    input  logic              ce_evt_i,
    input  logic [ADDR_W-1:0] ce_addr_i,
    input  logic [DATA_W-1:0] ce_data_i,
    input  logic [SYN_W-1:0]  ce_syn_i,
    input  logic              ue_evt_i,
    input  logic [ADDR_W-1:0] ue_addr_i,
    input  logic [DATA_W-1:0] ue_data_i,
    input  logic [SYN_W-1:0]  ue_syn_i,
    input  logic              init_evt_i,
    input  logic              reg_wr_i,
    input  logic [RIDX_W-1:0] reg_idx_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    localparam int AHI_W = ADDR_W - WORD_W;
    localparam int DHI_W = DATA_W - WORD_W;
    localparam int ECAP_W = ADDR_W + DATA_W + SYN_W;

    typedef struct packed {
        logic              init;
        logic              ecc;
        logic [STAT_W-1:0] mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NCLS-1:0]   evt;
    logic [NCLS-1:0]   cls_single;
    logic [NCLS-1:0]   cls_multi;
    logic [NCLS-1:0]   cls_cap;
    logic [STAT_W-1:0] ack;
    logic              mask_wr;

    logic [ADDR_W-1:0] evt_addr [NCLS];
    logic [DATA_W-1:0] evt_data [NCLS];
    logic [SYN_W-1:0]  evt_syn  [NCLS];
    logic [ADDR_W-1:0] cap_addr [NCLS];
    logic [DATA_W-1:0] cap_data [NCLS];
    logic [SYN_W-1:0]  cap_syn  [NCLS];

    assign evt[CLS_OOR] = oor_evt_i;
    assign evt[CLS_CE]  = ce_evt_i;
    assign evt[CLS_UE]  = ue_evt_i;

    assign evt_addr[CLS_OOR] = oor_addr_i;
    assign evt_addr[CLS_CE]  = ce_addr_i;
    assign evt_addr[CLS_UE]  = ue_addr_i;
    assign evt_data[CLS_OOR] = '0;
    assign evt_data[CLS_CE]  = ce_data_i;
    assign evt_data[CLS_UE]  = ue_data_i;
    assign evt_syn[CLS_OOR]  = '0;
    assign evt_syn[CLS_CE]   = ce_syn_i;
    assign evt_syn[CLS_UE]   = ue_syn_i;

    assign ack     = (reg_wr_i && reg_idx_i == RI_STATUS) ? reg_wdata_i[STAT_W-1:0] : '0;
    assign mask_wr = reg_wr_i && reg_idx_i == RI_MASK;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        memerr_cls_trk u_trk (
            .clk          (clk),
            .rst_n        (rst_n),
            .evt_i        (evt[c]),
            .ack_single_i (ack[2*c]),
            .ack_multi_i  (ack[2*c+1]),
            .single_o     (cls_single[c]),
            .multi_o      (cls_multi[c]),
            .capture_o    (cls_cap[c])
        );

        if (c == CLS_OOR) begin : g_addr_only
            memerr_capture #(.W(ADDR_W)) u_cap (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (cls_cap[c]),
                .d_i   (evt_addr[c]),
                .q_o   (cap_addr[c])
            );
            assign cap_data[c] = '0;
            assign cap_syn[c]  = '0;
        end else begin : g_full
            logic [ECAP_W-1:0] cap_word;
            memerr_capture #(.W(ECAP_W)) u_cap (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (cls_cap[c]),
                .d_i   ({evt_addr[c], evt_data[c], evt_syn[c]}),
                .q_o   (cap_word)
            );
            assign {cap_addr[c], cap_data[c], cap_syn[c]} = cap_word;
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.init = (ctl_q.init & ~ack[ST_INIT]) | init_evt_i;
        ctl_d.ecc  = (ctl_q.ecc & ~ack[ST_ECC]) | evt[CLS_CE] | evt[CLS_UE];
        if (mask_wr) ctl_d.mask = reg_wdata_i[STAT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.init <= 1'b0;
            ctl_q.ecc  <= 1'b0;
            ctl_q.mask <= MASK_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        status_o = '0;
        for (int c = 0; c < NCLS; c++) begin
            status_o[2*c]   = cls_single[c];
            status_o[2*c+1] = cls_multi[c];
        end
        status_o[ST_INIT] = ctl_q.init;
        status_o[ST_ECC]  = ctl_q.ecc;
    end

    assign irq_o = |(status_o & ~ctl_q.mask);

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_idx_i)
            RI_STATUS: reg_rdata_o[STAT_W-1:0] = status_o;
            RI_MASK:   reg_rdata_o[STAT_W-1:0] = ctl_q.mask;
            RI_OOR_AL: reg_rdata_o = cap_addr[CLS_OOR][WORD_W-1:0];
            RI_OOR_AH: reg_rdata_o[AHI_W-1:0] = cap_addr[CLS_OOR][ADDR_W-1:WORD_W];
            RI_CE_AL:  reg_rdata_o = cap_addr[CLS_CE][WORD_W-1:0];
            RI_CE_AH:  reg_rdata_o[AHI_W-1:0] = cap_addr[CLS_CE][ADDR_W-1:WORD_W];
            RI_CE_DL:  reg_rdata_o = cap_data[CLS_CE][WORD_W-1:0];
            RI_CE_DH:  reg_rdata_o[DHI_W-1:0] = cap_data[CLS_CE][DATA_W-1:WORD_W];
            RI_UE_AL:  reg_rdata_o = cap_addr[CLS_UE][WORD_W-1:0];
            RI_UE_AH:  reg_rdata_o[AHI_W-1:0] = cap_addr[CLS_UE][ADDR_W-1:WORD_W];
            RI_UE_DL:  reg_rdata_o = cap_data[CLS_UE][WORD_W-1:0];
            RI_UE_DH:  reg_rdata_o[DHI_W-1:0] = cap_data[CLS_UE][DATA_W-1:WORD_W];
            RI_SYN: begin
                reg_rdata_o[16 +: SYN_W] = cap_syn[CLS_CE];
                reg_rdata_o[8  +: SYN_W] = cap_syn[CLS_UE];
            end
            default:   reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/memerr_status_chk.sv
module memerr_status_chk
    import memerr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              oor_evt,
    input logic              ce_evt,
    input logic              ue_evt,
    input logic              init_evt,
    input logic              reg_wr,
    input logic [RIDX_W-1:0] reg_idx,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] status,
    input logic              irq,
    input logic [STAT_W-1:0] mask
);
    logic ack_wr;
    assign ack_wr = reg_wr && reg_idx == RI_STATUS;

    assert_ce_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |=> status[2] && status[ST_ECC]);

    assert_ue_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ue_evt |=> status[4] && status[ST_ECC]);

    assert_oor_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oor_evt |=> status[0]);

    assert_ce_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_evt && status[2] && !(ack_wr && reg_wdata[2]) && !(ack_wr && reg_wdata[3])) |=> status[3]);

    assert_init_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_evt |=> status[ST_INIT]);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && reg_wdata[0] && !oor_evt) |=> !status[0]);

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_evt && ack_wr && reg_wdata[2] && reg_wdata[3]) |=> status[2] && !status[3]);

    assert_all_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);
endmodule

bind memerr_status_regs memerr_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .oor_evt   (oor_evt_i),
    .ce_evt    (ce_evt_i),
    .ue_evt    (ue_evt_i),
    .init_evt  (init_evt_i),
    .reg_wr    (reg_wr_i),
    .reg_idx   (reg_idx_i),
    .reg_wdata (reg_wdata_i),
    .status    (status_o),
    .irq       (irq_o),
    .mask      (ctl_q.mask)
);

// File: tb/memerr_status_regs_tb.sv
module memerr_status_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        oor_evt_i, ce_evt_i, ue_evt_i, init_evt_i;
    logic [32:0] oor_addr_i, ce_addr_i, ue_addr_i;
    logic [63:0] ce_data_i, ue_data_i;
    logic [7:0]  ce_syn_i, ue_syn_i;
    logic        reg_wr_i;
    logic [3:0]  reg_idx_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] reg_rdata_o;
    logic [7:0]  status_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 register read, 1 status port, 2 interrupt
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    memerr_status_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .oor_evt_i(oor_evt_i), .oor_addr_i(oor_addr_i),
        .ce_evt_i(ce_evt_i), .ce_addr_i(ce_addr_i), .ce_data_i(ce_data_i), .ce_syn_i(ce_syn_i),
        .ue_evt_i(ue_evt_i), .ue_addr_i(ue_addr_i), .ue_data_i(ue_data_i), .ue_syn_i(ue_syn_i),
        .init_evt_i(init_evt_i),
        .reg_wr_i(reg_wr_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .status_o(status_o), .irq_o(irq_o)
    );

    // monitor: compares queued expectations a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = reg_rdata_o;
                    1:       act = {24'b0, status_o};
                    default: act = {31'b0, irq_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic exp_reg(input logic [3:0] idx, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_idx_i = idx;
        q.push_back('{kind: 0, exp: e, tag: tag});
    endtask

    task automatic exp_stat(input logic [7:0] e, input string tag);
        @(negedge clk);
        q.push_back('{kind: 1, exp: {24'b0, e}, tag: tag});
    endtask

    task automatic exp_irq(input logic e, input string tag);
        @(negedge clk);
        q.push_back('{kind: 2, exp: {31'b0, e}, tag: tag});
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic pulse_ce(input logic [32:0] a, input logic [63:0] d, input logic [7:0] s,
                            input logic ack_too, input logic [7:0] ack_bits);
        @(negedge clk);
        ce_evt_i = 1'b1; ce_addr_i = a; ce_data_i = d; ce_syn_i = s;
        if (ack_too) begin
            reg_wr_i = 1'b1; reg_idx_i = 4'd0; reg_wdata_i = {24'b0, ack_bits};
        end
        @(negedge clk);
        ce_evt_i = 1'b0; reg_wr_i = 1'b0;
    endtask

    task automatic pulse_ue(input logic [32:0] a, input logic [63:0] d, input logic [7:0] s);
        @(negedge clk);
        ue_evt_i = 1'b1; ue_addr_i = a; ue_data_i = d; ue_syn_i = s;
        @(negedge clk);
        ue_evt_i = 1'b0;
    endtask

    task automatic pulse_oor(input logic [32:0] a);
        @(negedge clk);
        oor_evt_i = 1'b1; oor_addr_i = a;
        @(negedge clk);
        oor_evt_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        oor_evt_i = 0; ce_evt_i = 0; ue_evt_i = 0; init_evt_i = 0;
        oor_addr_i = '0; ce_addr_i = '0; ue_addr_i = '0;
        ce_data_i = '0; ue_data_i = '0; ce_syn_i = '0; ue_syn_i = '0;
        reg_wr_i = 0; reg_idx_i = '0; reg_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_stat(8'h00, "R1 status");
        exp_irq(1'b0, "R1 irq");
        exp_reg(4'd1, 32'h0000_00FF, "R1 mask");
        exp_reg(4'd4, 32'h0, "R1 ce addr");
        exp_reg(4'd12, 32'h0, "R1 syndrome");

        // R2 single correctable event
        pulse_ce(33'h1_0000_0040, 64'hCAFE_F00D_1234_ABCD, 8'hD6, 1'b0, 8'h00);
        exp_stat(8'h84, "R2 status");
        exp_irq(1'b0, "R9 all masked");
        exp_reg(4'd4, 32'h0000_0040, "R2 ce addr lo");
        exp_reg(4'd5, 32'h0000_0001, "R10 ce addr hi");
        exp_reg(4'd6, 32'h1234_ABCD, "R2 ce data lo");
        exp_reg(4'd7, 32'hCAFE_F00D, "R2 ce data hi");
        exp_reg(4'd12, 32'h00D6_0000, "R2 syndrome");

        // R5 repeat correctable event
        pulse_ce(33'h0_0000_0BAD, 64'h1, 8'h11, 1'b0, 8'h00);
        exp_stat(8'h8C, "R5 ce repeat status");
        exp_reg(4'd4, 32'h0000_0040, "R5 ce addr frozen");
        exp_reg(4'd12, 32'h00D6_0000, "R5 syndrome frozen");

        // R9 unmask correctable bits
        wr(4'd1, 32'h0000_00F3);
        exp_reg(4'd1, 32'h0000_00F3, "R9 mask readback");
        exp_irq(1'b1, "R9 irq unmasked");

        // R7 acknowledge
        wr(4'd0, 32'h0000_008C);
        exp_stat(8'h00, "R7 ack all ce");
        exp_irq(1'b0, "R9 irq after ack");

        // R3 uncorrectable
        pulse_ue(33'h0_1234_5678, 64'h0123_4567_89AB_CDEF, 8'h5B);
        exp_stat(8'h90, "R3 status");
        exp_reg(4'd8, 32'h1234_5678, "R10 ue addr lo");
        exp_reg(4'd9, 32'h0, "R10 ue addr hi");
        exp_reg(4'd10, 32'h89AB_CDEF, "R3 ue data lo");
        exp_reg(4'd11, 32'h0123_4567, "R3 ue data hi");
        exp_reg(4'd12, 32'h00D6_5B00, "R3 syndrome");

        // R7 partial ack
        wr(4'd0, 32'h0000_0010);
        exp_stat(8'h80, "R7 partial ack");

        // R4 out-of-range
        pulse_oor(33'h1_FFFF_FFF0);
        exp_stat(8'h81, "R4 status");
        exp_reg(4'd2, 32'hFFFF_FFF0, "R4 oor addr lo");
        exp_reg(4'd3, 32'h0000_0001, "R10 oor addr hi");
        pulse_oor(33'h0_0000_0004);
        exp_stat(8'h83, "R5 oor repeat");
        exp_reg(4'd2, 32'hFFFF_FFF0, "R5 oor addr frozen");

        // R6 init complete
        @(negedge clk); init_evt_i = 1'b1;
        @(negedge clk); init_evt_i = 1'b0;
        exp_stat(8'hC3, "R6 status");
        exp_irq(1'b0, "R9 masked bits only");

        wr(4'd0, 32'h0000_00FF);
        exp_stat(8'h00, "R7 ack all");

        // R8 event wins over same-cycle acknowledge
        pulse_ce(33'h0_0000_1000, 64'h2, 8'h22, 1'b0, 8'h00);
        exp_stat(8'h84, "R2 status again");
        pulse_ce(33'h0_0000_2000, 64'h3, 8'h33, 1'b1, 8'h0C);
        exp_stat(8'h84, "R8 status");
        exp_reg(4'd4, 32'h0000_2000, "R8 capture refreshed");
        exp_reg(4'd12, 32'h0033_5B00, "R8 syndrome refreshed");
        pulse_ce(33'h0_0000_3000, 64'h4, 8'h44, 1'b1, 8'h84);
        exp_stat(8'h84, "R8 ecc bit kept");
        exp_reg(4'd4, 32'h0000_3000, "R8 capture after full ack");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (every requirement): actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule